// File: doc/BRIEF.md
# SPI Master Serial Engine

This block is the shifting core of a register-programmed SPI master. A small control word selects clock polarity, clock phase and frame length (4, 8 or 16 bits). A divider word sets the serial clock rate, and a select mask drives two active-low chip selects. Whenever the engine is enabled, a slave is selected and the transmit queue holds a word, the engine pops one word and shifts it out MSB first on `mosi`. At the same time it samples `miso`. When the frame is complete it pushes the received word into the receive queue.

The serial clock rests at the polarity level between frames. `busy` stays high for the whole time a frame is on the wire. Software uses it to know when the slave may be deselected. Configuration is meant to be changed only while the engine is disabled. Dropping the enable abandons a frame in flight.

Top module: `spi_shift_master`

## Requirements
- R1: Bit 7 of `ctrl_word` is the clock polarity and bit 6 the clock phase; bits 5:2 have no effect. Whenever `busy` is low, `sclk` equals the polarity bit from the previous cycle.
- R2: Bits 1:0 of `ctrl_word` select the frame length: 0 gives 4 bits, 1 gives 8 bits, 2 gives 16 bits, and the reserved code 3 behaves as 8 bits. Frames sit right-aligned in the 16-bit queue words. Transmit bits above the frame length are ignored, and the received word has zeros above the frame length.
- R3: Bits go out and come in MSB first. With phase 0, the first bit is on `mosi` before the first clock edge; `miso` is sampled on odd edges and `mosi` changes on even edges. With phase 1, `mosi` changes on odd edges and `miso` is sampled on even edges.
- R4: Each half period of `sclk` lasts `baud_div >> 1` input clocks, or 1 clock when that value is 0. Bit 0 of the divider is ignored, and values 0 and 1 both act as 2. A frame of N bits therefore keeps `busy` high for exactly 2*N*half clocks.
- R5: `cs_n[i]` is low, one cycle after the inputs change, exactly when `enable` is high and `sel_mask[i]` is 1. When `enable` is low, both outputs are high.
- R6: `tx_pop` is a single-cycle pulse issued only while idle with `enable` high, `sel_mask` nonzero and `tx_empty` low. `tx_data` is taken in that same cycle, and `busy` is high in the next cycle.
- R7: `rx_push` pulses for one cycle, in the cycle after the last clock edge of a frame, with the received word on `rx_data`. During that cycle `busy` is already low.
- R8: Dropping `enable` during a frame returns the engine to idle on the next edge. `busy` goes low, `sclk` goes back to the polarity level, and no word is pushed.
- R9: While `sel_mask` is zero, no frame starts and `tx_pop` stays low, even if the transmit queue holds data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Engine enable |
| ctrl_word | input | 8 | Polarity (7), phase (6), frame length code (1:0) |
| baud_div | input | 16 | Serial clock divider |
| sel_mask | input | 2 | Slave select, one bit per slave |
| tx_empty | input | 1 | Transmit queue is empty |
| tx_data | input | 16 | Head word of the transmit queue |
| tx_pop | output | 1 | Pop the transmit queue |
| rx_push | output | 1 | Push `rx_data` into the receive queue |
| rx_data | output | 16 | Received frame, right-aligned |
| busy | output | 1 | A frame is being shifted |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 2 | Active-low chip selects |

## Verification
The bench builds the engine with its default parameters: 16-bit queue words, a 16-bit divider and two chip selects. With these values every frame-length code is reachable, including the reserved one. The divider corner values 0, 1 and an odd divider can be applied, and a divider large enough to leave a wide window for abandoning a frame mid-shift. A slave model on the serial pins returns chosen reply words and captures `mosi`, so all four clock modes are checked from both directions.

// File: rtl/sme_pkg.sv
package sme_pkg;

  // Frame length codes carried in the low two bits of the control word.
  localparam logic [1:0] SZ_4  = 2'd0;
  localparam logic [1:0] SZ_8  = 2'd1;
  localparam logic [1:0] SZ_16 = 2'd2;

  localparam int LEN_W = 5;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_SHIFT = 1'b1
  } sme_state_e;

  // Bits per frame for a size code; the reserved code falls back to 8.
  function automatic logic [LEN_W-1:0] frame_len(input logic [1:0] code);
    logic [LEN_W-1:0] n;
    case (code)
      SZ_4:    n = 5'd4;
      SZ_16:   n = 5'd16;
      default: n = 5'd8;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/sme_baud_tick.sv
// Half-period timer: one tick per serial clock edge while running.
module sme_baud_tick #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  localparam int HALF_W = DIV_W - 1;

  logic [HALF_W-1:0] half;
  logic [HALF_W-1:0] cnt_q, cnt_d;
  logic              unused_div;

  assign unused_div = div[0];

  // Even divider with a floor of 2: half period is div/2, at least 1.
  always_comb begin
    if (div[DIV_W-1:1] == '0) half = HALF_W'(1);
    else                      half = div[DIV_W-1:1];
  end

  assign tick = run && (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (!run)           cnt_d = half - HALF_W'(1);
    else if (cnt_q == '0) cnt_d = half - HALF_W'(1);
    else                cnt_d = cnt_q - HALF_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/sme_sequencer.sv
// Frame sequencer: start/abort decisions, edge counting, serial clock.
module sme_sequencer
  import sme_pkg::*;
#(
  parameter int EDGE_W = LEN_W + 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       sel_any,
  input  logic       tx_empty,
  input  logic       pol_in,
  input  logic       pha_in,
  input  logic [1:0] size_in,
  input  logic       tick,
  output logic       start,
  output logic       busy,
  output logic       sclk,
  output logic       drive,
  output logic       sample,
  output logic       done
);
  sme_state_e        st_q, st_d;
  logic              sclk_q, sclk_d;
  logic [EDGE_W-1:0] ecnt_q, ecnt_d;
  logic              pha_q, pha_d;
  logic [LEN_W-1:0]  len_q, len_d;

  logic abort, step, odd_edge, last_edge;

  assign busy  = (st_q == ST_SHIFT);
  assign sclk  = sclk_q;

  assign start = (st_q == ST_IDLE) && en && sel_any && !tx_empty;
  assign abort = (st_q == ST_SHIFT) && !en;
  assign step  = (st_q == ST_SHIFT) && en && tick;

  // The edge about to happen is number ecnt_q+1 (1-based).
  assign odd_edge  = !ecnt_q[0];
  assign last_edge = (ecnt_q == ({len_q, 1'b0} - EDGE_W'(1)));

  assign drive  = step && (pha_q ? odd_edge : (!odd_edge && !last_edge));
  assign sample = step && (pha_q ? !odd_edge : odd_edge);
  assign done   = step && last_edge;

  always_comb begin
    st_d   = st_q;
    ecnt_d = ecnt_q;
    pha_d  = pha_q;
    len_d  = len_q;
    if (start) begin
      st_d   = ST_SHIFT;
      ecnt_d = '0;
      pha_d  = pha_in;
      len_d  = frame_len(size_in);
    end else if (abort || done) begin
      st_d   = ST_IDLE;
    end else if (step) begin
      ecnt_d = ecnt_q + EDGE_W'(1);
    end
  end

  always_comb begin
    if ((st_q == ST_IDLE) || abort) sclk_d = pol_in;
    else if (step)                  sclk_d = ~sclk_q;
    else                            sclk_d = sclk_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      sclk_q <= 1'b0;
      ecnt_q <= '0;
      pha_q  <= 1'b0;
      len_q  <= 5'd8;
    end else begin
      st_q   <= st_d;
      sclk_q <= sclk_d;
      ecnt_q <= ecnt_d;
      pha_q  <= pha_d;
      len_q  <= len_d;
    end
  end

endmodule

// File: rtl/sme_shifter.sv
// Transmit and receive shift registers with MSB-first ordering.
module sme_shifter
  import sme_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              pha_in,
  input  logic [1:0]        size_in,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              drive,
  input  logic              sample,
  input  logic              done,
  input  logic              miso,
  output logic              mosi,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_push
);
  logic [DATA_W-1:0] aligned;
  logic [DATA_W-1:0] txs_q, txs_d;
  logic [DATA_W-1:0] rxs_q, rxs_d, rxs_next;
  logic [DATA_W-1:0] rxd_q, rxd_d;
  logic              mosi_q, mosi_d;
  logic              push_q;

  // Left-justify the frame so its MSB leaves first; upper bits drop off.
  assign aligned = tx_data << (DATA_W - int'(frame_len(size_in)));

  assign rxs_next = sample ? {rxs_q[DATA_W-2:0], miso} : rxs_q;

  always_comb begin
    txs_d  = txs_q;
    mosi_d = mosi_q;
    if (load) begin
      if (!pha_in) {mosi_d, txs_d} = {aligned, 1'b0};
      else         txs_d = aligned;
    end else if (drive) begin
      {mosi_d, txs_d} = {txs_q, 1'b0};
    end
  end

  always_comb begin
    rxs_d = load ? '0 : rxs_next;
    rxd_d = done ? rxs_next : rxd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txs_q  <= '0;
      mosi_q <= 1'b0;
      rxs_q  <= '0;
      rxd_q  <= '0;
      push_q <= 1'b0;
    end else begin
      txs_q  <= txs_d;
      mosi_q <= mosi_d;
      rxs_q  <= rxs_d;
      rxd_q  <= rxd_d;
      push_q <= done;
    end
  end

  assign mosi    = mosi_q;
  assign rx_data = rxd_q;
  assign rx_push = push_q;

endmodule

// File: rtl/spi_shift_master.sv
// SPI master serial engine: top level.
module spi_shift_master #(
  parameter int DATA_W = 16,
  parameter int DIV_W  = 16,
  parameter int CS_NUM = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [7:0]        ctrl_word,
  input  logic [DIV_W-1:0]  baud_div,
  input  logic [CS_NUM-1:0] sel_mask,
  input  logic              tx_empty,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_pop,
  output logic              rx_push,
  output logic [DATA_W-1:0] rx_data,
  output logic              busy,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [CS_NUM-1:0] cs_n
);
  localparam int POL_BIT = 7;
  localparam int PHA_BIT = 6;

  logic [1:0]        rst_sync_q;
  logic              rst_core_n;
  logic              en_i;
  logic              tick, start, drive, sample, done;
  logic [CS_NUM-1:0] cs_q, cs_d;
  logic              unused_ctrl;

  assign unused_ctrl = ^ctrl_word[5:2];

  // Asynchronous assert, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  assign en_i   = enable && rst_core_n;
  assign tx_pop = start;

  sme_baud_tick #(.DIV_W(DIV_W)) u_baud (
    .clk   (clk),
    .rst_n (rst_core_n),
    .run   (busy),
    .div   (baud_div),
    .tick  (tick)
  );

  sme_sequencer u_seq (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .en       (en_i),
    .sel_any  (|sel_mask),
    .tx_empty (tx_empty),
    .pol_in   (ctrl_word[POL_BIT]),
    .pha_in   (ctrl_word[PHA_BIT]),
    .size_in  (ctrl_word[1:0]),
    .tick     (tick),
    .start    (start),
    .busy     (busy),
    .sclk     (sclk),
    .drive    (drive),
    .sample   (sample),
    .done     (done)
  );

  sme_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .load    (start),
    .pha_in  (ctrl_word[PHA_BIT]),
    .size_in (ctrl_word[1:0]),
    .tx_data (tx_data),
    .drive   (drive),
    .sample  (sample),
    .done    (done),
    .miso    (miso),
    .mosi    (mosi),
    .rx_data (rx_data),
    .rx_push (rx_push)
  );

  // One registered active-low select per slave.
  for (genvar i = 0; i < CS_NUM; i++) begin : g_cs
    always_comb cs_d[i] = ~(en_i & sel_mask[i]);
    always_ff @(posedge clk or negedge rst_core_n) begin
      if (!rst_core_n) cs_q[i] <= 1'b1;
      else             cs_q[i] <= cs_d[i];
    end
  end

  assign cs_n = cs_q;

endmodule

// File: rtl/sme_checker.sv
module sme_checker #(
  parameter int DATA_W = 16,
  parameter int CS_NUM = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic [7:0]        ctrl_word,
  input logic [CS_NUM-1:0] sel_mask,
  input logic              tx_pop,
  input logic              busy,
  input logic              sclk,
  input logic              rx_push,
  input logic [DATA_W-1:0] rx_data,
  input logic [CS_NUM-1:0] cs_n
);
  // R1: idle clock level follows polarity
  a_r1_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> (sclk == $past(ctrl_word[7])));

  // R2: 4-bit frames carry zeros above bit 3
  a_r2_zero_upper: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && ctrl_word[1:0] == 2'd0) |-> (rx_data[DATA_W-1:4] == '0));

  // R5: disabled engine releases every select
  a_r5_cs_release: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (cs_n == '1));

  // R6: pop only from idle, and a frame follows
  a_r6_pop_idle: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |-> !busy);
  a_r6_pop_then_busy: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |=> busy);

  // R7: push closes a frame
  a_r7_push_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> (!busy && $past(busy)));

  // R8: disable ends any frame
  a_r8_disable_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !busy);

  // R9: no selection, no pop
  a_r9_no_sel_no_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_mask == '0) |-> !tx_pop);

endmodule

bind spi_shift_master sme_checker #(.DATA_W(DATA_W), .CS_NUM(CS_NUM)) u_chk (
  .clk       (clk),
  .rst_n     (rst_core_n),
  .enable    (enable),
  .ctrl_word (ctrl_word),
  .sel_mask  (sel_mask),
  .tx_pop    (tx_pop),
  .busy      (busy),
  .sclk      (sclk),
  .rx_push   (rx_push),
  .rx_data   (rx_data),
  .cs_n      (cs_n)
);

// File: tb/sim_spi_shift_master.sv
`timescale 1ns/1ps
module sim_spi_shift_master;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        enable;
  logic [7:0]  ctrl_word;
  logic [15:0] baud_div;
  logic [1:0]  sel_mask;
  logic        tx_empty;
  logic [15:0] tx_data;
  logic        tx_pop, rx_push, busy, sclk, mosi, miso;
  logic [15:0] rx_data;
  logic [1:0]  cs_n;

  always #5 clk = ~clk;

  spi_shift_master u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .ctrl_word(ctrl_word),
    .baud_div(baud_div), .sel_mask(sel_mask), .tx_empty(tx_empty),
    .tx_data(tx_data), .tx_pop(tx_pop), .rx_push(rx_push), .rx_data(rx_data),
    .busy(busy), .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
  );

  int n_checks = 0;
  int n_errors = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Transmit queue model (pointers move on the clock edge)
  logic [15:0] txm [0:63];
  logic [6:0]  wr_p, rd_p;
  assign tx_empty = (wr_p == rd_p);
  assign tx_data  = txm[rd_p[5:0]];
  always @(posedge clk) if (tx_pop) rd_p <= rd_p + 7'd1;

  // Scoreboard
  typedef struct { int rx; int cyc; } exp_t;
  exp_t exp_q[$];
  int   mo_q[$];
  int   reply_q[$];

  function automatic int nbits(input logic [1:0] c);
    return (c == 2'd0) ? 4 : (c == 2'd2) ? 16 : 8;
  endfunction

  function automatic int halfp(input logic [15:0] d);
    return (d[15:1] == 0) ? 1 : int'(d[15:1]);
  endfunction

  task automatic push_raw(input logic [15:0] d, input logic [15:0] reply);
    reply_q.push_back(int'(reply));
    txm[wr_p[5:0]] = d;
    wr_p = wr_p + 7'd1;
  endtask

  task automatic send(input logic [15:0] d, input logic [15:0] reply);
    int n;
    int m;
    exp_t e;
    n = nbits(ctrl_word[1:0]);
    m = (1 << n) - 1;
    e.rx  = int'(reply) & m;
    e.cyc = 2 * n * halfp(baud_div);
    exp_q.push_back(e);
    mo_q.push_back(int'(d) & m);
    push_raw(d, reply);
  endtask

  // Slave model on the serial pins, evaluated mid-cycle
  logic sl_pb, sl_ps, sl_act;
  int   sl_cnt, sl_n, sl_cap;
  logic [15:0] sl_sh;
  always @(negedge clk) begin
    if (!rst_n) begin
      sl_pb = 0; sl_ps = 0; sl_act = 0; miso = 0;
    end else begin
      if (busy && !sl_pb) begin
        sl_act = 1; sl_cnt = 0; sl_cap = 0;
        sl_n = nbits(ctrl_word[1:0]);
        sl_sh = (reply_q.size() > 0) ? 16'(reply_q.pop_front()) : 16'h0;
        sl_sh = sl_sh << (16 - sl_n);
        if (!ctrl_word[6]) begin miso = sl_sh[15]; sl_sh = sl_sh << 1; end
      end else if (sl_act && sclk !== sl_ps) begin
        sl_cnt++;
        if ((sl_cnt % 2 == 1) != ctrl_word[6]) sl_cap = (sl_cap << 1) | int'(mosi);
        else begin miso = sl_sh[15]; sl_sh = sl_sh << 1; end
        if (sl_cnt == 2 * sl_n) begin
          sl_act = 0;
          if (mo_q.size() == 0) chk(0, "R3 unexpected mosi frame", sl_cap, 0);
          else begin
            int e;
            e = mo_q.pop_front();
            chk(sl_cap == e, "R3 mosi bits", sl_cap, e);
          end
        end
      end
      if (!busy && sl_pb) sl_act = 0;
      sl_pb = busy; sl_ps = sclk;
    end
  end

  // Monitor on the receive side
  logic mprev;
  int   bcnt;
  int   pushes;
  always @(negedge clk) begin
    if (!rst_n) begin
      mprev = 0; bcnt = 0; pushes = 0;
    end else begin
      if (busy && !mprev) bcnt = 1;
      else if (busy) bcnt++;
      mprev = busy;
      if (rx_push) begin
        pushes++;
        if (exp_q.size() == 0) chk(0, "R8 unexpected rx_push", int'(rx_data), 0);
        else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(int'(rx_data) == e.rx, "R2 rx word", int'(rx_data), e.rx);
          chk(bcnt == e.cyc, "R4 busy length", bcnt, e.cyc);
          chk(busy == 1'b0, "R7 busy low at push", int'(busy), 0);
          chk(sclk == ctrl_word[7], "R1 clock back at polarity", int'(sclk), int'(ctrl_word[7]));
        end
      end
    end
  end

  task automatic wait_idle;
    int k;
    k = 0;
    while ((exp_q.size() != 0 || mo_q.size() != 0 || busy || rd_p != wr_p) && k < 20000) begin
      @(negedge clk); k++;
    end
    chk(k < 20000, "R6 queue drained", k, 0);
    repeat (2) @(negedge clk);
  endtask

  task automatic set_cfg(input logic [7:0] c, input logic [15:0] d, input logic [1:0] s);
    enable = 0;
    @(negedge clk);
    ctrl_word = c; baud_div = d; sel_mask = s;
    @(negedge clk);
    enable = 1;
    @(negedge clk);
  endtask

  task automatic cfg(input logic [7:0] c, input logic [15:0] d, input logic [1:0] s);
    wait_idle();
    set_cfg(c, d, s);
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    int busy_seen;
    int start_push;
    rst_n = 0; enable = 0; ctrl_word = 8'h01; baud_div = 16'd4; sel_mask = 2'b00;
    wr_p = 0; rd_p = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    chk(busy == 0, "R7 reset busy", int'(busy), 0);
    chk(cs_n == 2'b11, "R5 reset cs_n", int'(cs_n), 3);
    chk(sclk == 0, "R1 reset sclk", int'(sclk), 0);
    chk(tx_pop == 0 && rx_push == 0, "R6 reset strobes", int'({tx_pop, rx_push}), 0);

    // Mode 0, 8-bit, back to back
    cfg(8'h01, 16'd4, 2'b01);
    chk(cs_n == 2'b10, "R5 select slave 0", int'(cs_n), 2);
    send(16'hFFA5, 16'h003C);
    send(16'h0081, 16'h00C3);
    @(negedge clk);
    chk(tx_pop == 0, "R6 pop is a single pulse", int'(tx_pop), 0);

    // Mode 1
    cfg(8'h41, 16'd4, 2'b01);
    send(16'h005A, 16'h0096);

    // Mode 2 on slave 1
    cfg(8'h81, 16'd6, 2'b10);
    chk(cs_n == 2'b01, "R5 select slave 1", int'(cs_n), 1);
    chk(sclk == 1, "R1 idle high with polarity 1", int'(sclk), 1);
    send(16'h000F, 16'h00F0);

    // Mode 3
    cfg(8'hC1, 16'd2, 2'b01);
    send(16'h0033, 16'h00CC);

    // 4-bit frames, upper bits of both words ignored
    cfg(8'h00, 16'd4, 2'b01);
    send(16'hFFF9, 16'hFFF6);

    // 16-bit frames in mode 3
    cfg(8'hC2, 16'd8, 2'b01);
    send(16'h1234, 16'hBEEF);
    send(16'hFFFF, 16'h0000);

    // Reserved size code behaves as 8 bits
    cfg(8'h03, 16'd4, 2'b01);
    send(16'h01C7, 16'h01E5);

    // Divider corner values
    cfg(8'h01, 16'd0, 2'b01);
    send(16'h0069, 16'h00A6);
    cfg(8'h01, 16'd1, 2'b01);
    send(16'h0055, 16'h00AA);
    cfg(8'h41, 16'd7, 2'b01);
    send(16'h00E1, 16'h001E);

    // Control bits 5:2 have no effect (R1)
    cfg(8'h3D, 16'd4, 2'b01);
    send(16'h00B4, 16'h004B);

    // R9: no selection holds the queue
    cfg(8'h01, 16'd4, 2'b00);
    send(16'h0077, 16'h0088);
    busy_seen = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (busy || tx_pop) busy_seen++;
    end
    chk(busy_seen == 0, "R9 no frame without selection", busy_seen, 0);
    chk(rd_p != wr_p, "R9 word left in queue", int'(rd_p), int'(wr_p) - 1);
    set_cfg(8'h01, 16'd4, 2'b01);
    wait_idle();

    // R8: abandon a frame, polarity 1 so the idle return is visible
    set_cfg(8'h81, 16'd40, 2'b01);
    start_push = pushes;
    push_raw(16'h00AB, 16'h00CD);
    while (!busy) @(negedge clk);
    repeat (50) @(negedge clk);
    enable = 0;
    @(negedge clk);
    chk(busy == 0, "R8 busy drops on disable", int'(busy), 0);
    chk(sclk == 1, "R8 clock back at polarity", int'(sclk), 1);
    chk(cs_n == 2'b11, "R5 disable releases selects", int'(cs_n), 3);
    repeat (400) @(negedge clk);
    chk(pushes == start_push, "R8 no push after abort", pushes - start_push, 0);

    // Normal traffic resumes after the abort
    set_cfg(8'h01, 16'd2, 2'b01);
    send(16'h00C6, 16'h0039);
    wait_idle();

    $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule